// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps the return addresses of a small processor core in storage of its own, apart from program and data memory. The sequencer raises a push strobe with a 15-bit address when it takes a call or accepts an interrupt. It raises a pop strobe for any form of return: a plain return, a return that loads a literal, or a return from interrupt. The current top entry is always on the return-address output, so the sequencer takes it in the same cycle as it pops. Software has no direct push or pop path.

The storage is a ring of sixteen slots. A push beyond sixteen held entries is not refused: it writes over the oldest entry and sets a sticky overflow flag. A pop from an empty stack still steps the pointer back around the ring and sets a sticky underflow flag. Both flags stay set until the clear input or reset removes them. A push and a pop in the same cycle replace the top entry in place.

Top module: `ret_stack`

## Requirements
- R1: After a synchronous reset, every slot holds zero, the stack is empty, the return-address output reads zero and both flags are low.
- R2: A push without a pop stores the push address as the new top. It appears on the return-address output in the cycle after the strobe.
- R3: A pop without a push removes the top entry, and the output then shows the entry pushed before it (last in, first out).
- R4: The ring holds 16 entries. After 17 pushes in a row the 17th address has overwritten the 1st, so 16 pops in a row then leave the 17th address on the output.
- R5: A push without a pop while 16 entries are held sets the overflow flag in the next cycle. The held count stays at 16.
- R6: A pop without a push while the stack is empty sets the underflow flag in the next cycle. The pointer still moves back one slot around the ring, the output then shows whatever that slot holds, and the held count stays at zero.
- R7: A push and a pop in the same cycle overwrite the top entry with the push address. The pointer and the held count stay unchanged and neither flag is set.
- R8: The flag clear input lowers both flags in the next cycle. If the same cycle also raises a flag, that flag is set.
- R9: Once set, each flag stays high through any later pushes and pops until it is cleared or reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push strobe (call taken or interrupt accepted) |
| push_addr | input | 15 | Address to save on push |
| pop_en | input | 1 | Pop strobe (any return) |
| flag_clr | input | 1 | Clears the overflow and underflow flags |
| ret_addr | output | 15 | Current top-of-stack return address |
| overflow | output | 1 | Sticky overflow flag |
| underflow | output | 1 | Sticky underflow flag |

## Verification
The assertions assume that push and pop strobes are single-cycle levels sampled at each edge. They also assume that reset is held across at least one edge before the first strobe, so that no property sees the output from before reset. Any mix of strobes and clear is legal, and the stimulus drives the full, empty, wrapped and simultaneous cases on purpose. It then runs a long pseudo-random mix of push, pop, both together and clear, and compares each cycle with a behavioural model.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int RS_DEPTH = 16;
    localparam int RS_AW    = 15;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } rs_op_e;

    typedef struct packed {
        logic ovf_hit;
        logic unf_hit;
    } rs_event_t;

    function automatic rs_op_e rs_decode(input logic push, input logic pop);
        rs_op_e op;
        case ({push, pop})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
    import rs_pkg::*;
#(
    parameter int DEPTH = RS_DEPTH,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  rs_op_e        op,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] top_idx,
    output logic [CW-1:0] count_q,
    output rs_event_t     evt
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_inc;

    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign top_idx = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    assign wr_idx  = (op == OP_SWAP) ? top_idx : ptr_q;

    always_comb begin
        evt.ovf_hit = (op == OP_PUSH) && (count_q == FULL);
        evt.unf_hit = (op == OP_POP) && (count_q == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            count_q <= '0;
        end else begin
            case (op)
                OP_PUSH: begin
                    ptr_q <= ptr_inc;
                    if (count_q != FULL) count_q <= count_q + 1'b1;
                end
                OP_POP: begin
                    ptr_q <= top_idx;
                    if (count_q != '0) count_q <= count_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rs_store.sv
module rs_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 15,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_data
);

    logic [AW-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[g] <= '0;
            else if (we && (wr_idx == PW'(g)))
                slot_q[g] <= wr_data;
        end
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/rs_flags.sv
module rs_flags
    import rs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  rs_event_t evt,
    output logic      ovf_q,
    output logic      unf_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ovf_q <= evt.ovf_hit | (ovf_q & ~clr);
            unf_q <= evt.unf_hit | (unf_q & ~clr);
        end
    end

endmodule

// File: rtl/ret_stack.sv
module ret_stack
    import rs_pkg::*;
#(
    parameter int DEPTH = RS_DEPTH,
    parameter int AW    = RS_AW,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_en,
    input  logic [AW-1:0] push_addr,
    input  logic          pop_en,
    input  logic          flag_clr,
    output logic [AW-1:0] ret_addr,
    output logic          overflow,
    output logic          underflow
);

    rs_op_e        op;
    rs_event_t     evt;
    logic [PW-1:0] wr_idx;
    logic [PW-1:0] top_idx;
    logic [CW-1:0] count_q;
    logic          store_we;

    assign op       = rs_decode(push_en, pop_en);
    assign store_we = (op == OP_PUSH) || (op == OP_SWAP);

    rs_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .wr_idx  (wr_idx),
        .top_idx (top_idx),
        .count_q (count_q),
        .evt     (evt)
    );

    rs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (store_we),
        .wr_idx  (wr_idx),
        .wr_data (push_addr),
        .rd_idx  (top_idx),
        .rd_data (ret_addr)
    );

    rs_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .clr   (flag_clr),
        .evt   (evt),
        .ovf_q (overflow),
        .unf_q (underflow)
    );

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
    parameter int DEPTH = 16,
    parameter int AW    = 15,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          push_en,
    input logic [AW-1:0] push_addr,
    input logic          pop_en,
    input logic          flag_clr,
    input logic [AW-1:0] ret_addr,
    input logic          overflow,
    input logic          underflow,
    input logic [CW-1:0] depth
);

    p_push_top_r2: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en) |=> (ret_addr == $past(push_addr)));

    p_lifo_r3: assert property (@(posedge clk) disable iff (rst)
        ((push_en && !pop_en) ##1 (pop_en && !push_en)) |=> (ret_addr == $past(ret_addr, 2)));

    p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
        (push_en && !pop_en && depth == CW'(DEPTH)) |=> (overflow && depth == CW'(DEPTH)));

    p_unf_set_r6: assert property (@(posedge clk) disable iff (rst)
        (pop_en && !push_en && depth == '0) |=> (underflow && depth == '0));

    p_swap_r7: assert property (@(posedge clk) disable iff (rst)
        (push_en && pop_en) |=> (ret_addr == $past(push_addr) && $stable(depth)));

    p_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !push_en && !pop_en) |=> (!overflow && !underflow));

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (overflow && !flag_clr) |=> overflow);

    p_unf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (underflow && !flag_clr) |=> underflow);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (ret_addr == '0 && !overflow && !underflow && depth == '0));

endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .push_addr (push_addr),
    .pop_en    (pop_en),
    .flag_clr  (flag_clr),
    .ret_addr  (ret_addr),
    .overflow  (overflow),
    .underflow (underflow),
    .depth     (count_q)
);

// File: tb/tb_ret_stack.sv
module tb_ret_stack;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_en = 1'b0;
    logic [14:0] push_addr = '0;
    logic        pop_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic [14:0] ret_addr;
    logic        overflow;
    logic        underflow;

    int checks = 0;
    int errors = 0;

    int m_mem [16];
    int m_ptr, m_cnt;
    bit m_ovf, m_unf;

    always #5 clk = ~clk;

    ret_stack dut (
        .clk(clk), .rst(rst), .push_en(push_en), .push_addr(push_addr),
        .pop_en(pop_en), .flag_clr(flag_clr), .ret_addr(ret_addr),
        .overflow(overflow), .underflow(underflow)
    );

    function automatic int m_top();
        return m_mem[(m_ptr + 15) % 16];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 16; i++) m_mem[i] = 0;
        m_ptr = 0; m_cnt = 0; m_ovf = 0; m_unf = 0;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (int'(ret_addr) != m_top() || overflow != m_ovf || underflow != m_unf) begin
            errors++;
            $display("FAIL %s: ret=%0d ovf=%0b unf=%0b expected ret=%0d ovf=%0b unf=%0b",
                     tag, ret_addr, overflow, underflow, m_top(), m_ovf, m_unf);
        end
    endtask

    task automatic expect_val(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit ps, input bit pp, input int a, input bit clr, input string tag);
        bit ovf_hit, unf_hit;
        push_en = ps; pop_en = pp; push_addr = 15'(a); flag_clr = clr;
        ovf_hit = ps && !pp && m_cnt == 16;
        unf_hit = pp && !ps && m_cnt == 0;
        if (ps && pp) begin
            m_mem[(m_ptr + 15) % 16] = a & 32'h7fff;
        end else if (ps) begin
            m_mem[m_ptr] = a & 32'h7fff;
            m_ptr = (m_ptr + 1) % 16;
            if (m_cnt < 16) m_cnt++;
        end else if (pp) begin
            m_ptr = (m_ptr + 15) % 16;
            if (m_cnt > 0) m_cnt--;
        end
        m_ovf = ovf_hit || (m_ovf && !clr);
        m_unf = unf_hit || (m_unf && !clr);
        @(posedge clk); #1;
        push_en = 0; pop_en = 0; flag_clr = 0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1;
        push_en = 0; pop_en = 0; flag_clr = 0;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        model_reset();
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        int a;
        do_reset();
        compare("R1 reset state");

        // R2 pushes, R3 pops
        step(1, 0, 15'h1234, 0, "R2 push 1");
        step(1, 0, 15'h0456, 0, "R2 push 2");
        step(1, 0, 15'h7fff, 0, "R2 push 3");
        expect_val("R2 top after 3 pushes", int'(ret_addr), 32'h7fff);
        step(0, 1, 0, 0, "R3 pop 1");
        expect_val("R3 lifo order", int'(ret_addr), 32'h0456);
        step(0, 1, 0, 0, "R3 pop 2");
        step(0, 1, 0, 0, "R3 pop 3");

        // R4/R5 wrap and overflow
        do_reset();
        for (int i = 0; i < 17; i++) step(1, 0, 100 + i, 0, "R4 fill");
        expect_val("R5 overflow after 17th push", int'(overflow), 1);
        for (int i = 0; i < 16; i++) step(0, 1, 0, 0, "R4 drain");
        expect_val("R4 17th address remains", int'(ret_addr), 116);
        expect_val("R9 overflow still set", int'(overflow), 1);

        // R6 underflow on empty pop
        step(0, 1, 0, 0, "R6 empty pop");
        expect_val("R6 underflow set", int'(underflow), 1);
        expect_val("R6 slot behind pointer", int'(ret_addr), 115);

        // R9 stickiness across traffic
        step(1, 0, 55, 0, "R9 push keeps flags");
        step(0, 1, 0, 0, "R9 pop keeps flags");

        // R8 clear, and set wins over clear
        step(0, 0, 0, 1, "R8 clear");
        expect_val("R8 flags low", int'(overflow) + int'(underflow), 0);
        do_reset();
        step(0, 1, 0, 1, "R8 set beats clear");
        expect_val("R8 underflow wins", int'(underflow), 1);

        // R7 simultaneous push and pop
        do_reset();
        step(1, 0, 11, 0, "R7 base push");
        step(1, 0, 22, 0, "R7 second push");
        step(1, 1, 33, 0, "R7 replace top");
        expect_val("R7 top replaced", int'(ret_addr), 33);
        step(0, 1, 0, 0, "R7 pop after replace");
        expect_val("R7 depth unchanged", int'(ret_addr), 11);
        step(1, 1, 44, 0, "R7 replace on one entry");
        step(0, 1, 0, 0, "R7 empty after replace");
        expect_val("R7 no flag from replace", int'(overflow), 0);

        // mixed traffic against the model
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = int'(lfsr) * 7;
            step(lfsr[0], lfsr[3] & lfsr[1], a, lfsr[7:4] == 4'hF, "R2/R3 mixed");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule